// File: doc/BRIEF.md
# Low-Frequency Clock Quality Monitor

This block judges the quality of an asynchronous low-frequency clock (nominally 32.768 kHz) by timing it against a fast reference clock. The slow input is synchronized into the reference domain. Each rising edge then closes one measured cycle, which has a period, a high time and a low time, all counted in reference cycles. A nominal cycle against a 48 MHz reference is about 1465 counts. Each closed cycle is compared against software-programmed limits. The result is recorded in sticky status flags.

Software first programs the minimum and maximum period, the largest allowed difference between high and low time, and the number of consecutive good cycles that qualify the clock as valid. It then turns on any mix of the period check, the duty check and the valid counter. Typical values for a 48 MHz reference are 1435, 1495, 74 and 4. A clock that stops toggling is reported as stalled. Status flags are cleared by writing ones to them. An interrupt line is raised for any flag that is both set and enabled.

Top module: `clk32_monitor`

## Requirements
- R1: After reset, status_o is 0 and irq_o is 0.
- R2: The write port uses these addresses: 0 control, 1 period minimum, 2 period maximum, 3 duty limit, 4 valid-count minimum (low 8 bits), 5 status (write-one-to-clear), 6 interrupt enable. In the control word, bit 0 enables the period check, bit 1 enables the duty check, bit 2 enables the valid counter, and bit 3 is a one-shot clear of the measurement state and the consecutive-good count. While control bits 2:0 are all 0, no status flag is set, whatever the input does.
- R3: The status bits are: bit 0 ready, bit 1 period-pass, bit 2 duty-pass, bit 3 valid, bit 4 fail, bit 5 stall. Bit 0 sets for every cycle that is closed after a clear. A cycle is closed by a rise, a fall and a rise. Its period is the number of reference cycles from rise to rise.
- R4: With the period check on, a period P with min <= P <= max sets bit 1. Any other period sets bit 4. With the period check off, the period affects neither flag.
- R5: With the duty check on, a cycle with |high - low| <= limit sets bit 2. Any other cycle sets bit 4. With the duty check off, duty has no effect.
- R6: With the valid counter on, bit 3 sets on the closed cycle at which the count of consecutive cycles passing all enabled checks reaches the valid-count minimum. A failing cycle restarts the count from zero, and so does the control clear bit.
- R7: While monitoring, bit 5 sets once no input edge has been seen for 2 x period-maximum reference cycles.
- R8: A write to the status address clears each bit written as 1 and leaves the other bits unchanged. A hardware set in the same cycle wins over the clear.
- R9: irq_o is 1 exactly when some status bit and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk32_i | input | 1 | Slow clock under test, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| status_o | output | 6 | Sticky status flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Two things can land in the same reference cycle: the hardware setting the ready flag as a cycle closes, and a software write-one-to-clear of that same flag. The bench places a rising input edge on a known negative clock edge. It then times the status write so that it is sampled on the exact edge on which the synchronized rise is evaluated. The flag must read back as set; a later plain write must clear it. Period and duty boundaries, good/bad sequences for the valid count, and stall timing are each compared against values the scoreboard works out from the requirements.

// File: rtl/c32m_pkg.sv
package c32m_pkg;
  localparam int ADDR_W = 3;
  localparam int ST_W   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER_MIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER_MAX = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY    = 3'd3;
  localparam logic [ADDR_W-1:0] A_VALMIN  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 3'd6;

  localparam int C_PER  = 0;
  localparam int C_DUTY = 1;
  localparam int C_VAL  = 2;
  localparam int C_CLR  = 3;

  localparam int S_RDY   = 0;
  localparam int S_PER   = 1;
  localparam int S_DUTY  = 2;
  localparam int S_VALID = 3;
  localparam int S_FAIL  = 4;
  localparam int S_STALL = 5;
endpackage

// File: rtl/c32m_sync.sv
module c32m_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/c32m_meas.sv
module c32m_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             mon_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] per_max_i,
  output logic             pulse_evt_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o,
  output logic             stall_evt_o
);
  localparam int IDLE_W = CNT_W + 1;

  logic             lvl_q, rise, fall, run;
  logic             seen_rise, have_hi;
  logic [CNT_W-1:0] per_cnt, high_q;
  logic [IDLE_W-1:0] idle_cnt, idle_lim;

  assign rise     = lvl_i & ~lvl_q;
  assign fall     = ~lvl_i & lvl_q;
  assign run      = mon_en_i & ~clr_i;
  assign idle_lim = {per_max_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt   <= '0;
      high_q    <= '0;
      seen_rise <= 1'b0;
      have_hi   <= 1'b0;
    end else if (!run) begin
      per_cnt   <= '0;
      seen_rise <= 1'b0;
      have_hi   <= 1'b0;
    end else begin
      if (rise)                per_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (per_cnt != '1)  per_cnt <= per_cnt + 1'b1;
      if (rise) begin
        seen_rise <= 1'b1;
        have_hi   <= 1'b0;
      end else if (fall && seen_rise) begin
        have_hi <= 1'b1;
        high_q  <= per_cnt;
      end
    end
  end

  // idle counter saturates past the limit so stall fires once per outage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_cnt <= '0;
    else if (!run || rise || fall) idle_cnt <= '0;
    else if (idle_cnt != '1)     idle_cnt <= idle_cnt + 1'b1;
  end

  assign pulse_evt_o = run & rise & have_hi;
  assign period_o    = per_cnt;
  assign high_o      = high_q;
  assign stall_evt_o = run & (idle_cnt == idle_lim);

  p_quiet_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |-> (!pulse_evt_o && !stall_evt_o));

  p_period_covers_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_evt_o && period_o != '1) |-> (period_o > high_o));
endmodule

// File: rtl/c32m_judge.sv
module c32m_judge
  import c32m_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_evt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             stall_evt_i,
  input  logic [CNT_W-1:0] per_min_i,
  input  logic [CNT_W-1:0] per_max_i,
  input  logic [CNT_W-1:0] duty_max_i,
  input  logic [VAL_W-1:0] val_min_i,
  input  logic             per_en_i,
  input  logic             duty_en_i,
  input  logic             val_en_i,
  input  logic             clr_i,
  output logic [ST_W-1:0]  set_o
);
  logic [CNT_W-1:0] low, diff;
  logic             per_ok, duty_ok, good;
  logic [VAL_W-1:0] val_cnt, val_next;

  assign low     = (high_i > period_i) ? '0 : period_i - high_i;
  assign diff    = (high_i >= low) ? high_i - low : low - high_i;
  assign per_ok  = (period_i >= per_min_i) && (period_i <= per_max_i);
  assign duty_ok = diff <= duty_max_i;
  assign good    = (!per_en_i || per_ok) && (!duty_en_i || duty_ok);
  assign val_next = (val_cnt == '1) ? val_cnt : val_cnt + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                val_cnt <= '0;
    else if (clr_i || !val_en_i) val_cnt <= '0;
    else if (pulse_evt_i)       val_cnt <= good ? val_next : '0;
  end

  always_comb begin
    set_o          = '0;
    set_o[S_RDY]   = pulse_evt_i;
    set_o[S_PER]   = pulse_evt_i & per_en_i & per_ok;
    set_o[S_DUTY]  = pulse_evt_i & duty_en_i & duty_ok;
    set_o[S_FAIL]  = pulse_evt_i & ~good;
    set_o[S_VALID] = pulse_evt_i & val_en_i & good & (val_next >= val_min_i);
    set_o[S_STALL] = stall_evt_i;
  end

  p_valid_not_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[S_VALID] |-> !set_o[S_FAIL]);

  p_pass_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[S_PER] |-> per_en_i);

  p_duty_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[S_DUTY] |-> duty_en_i);
endmodule

// File: rtl/c32m_regs.sv
module c32m_regs
  import c32m_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ST_W-1:0]   set_i,
  output logic              per_en_o,
  output logic              duty_en_o,
  output logic              val_en_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  per_min_o,
  output logic [CNT_W-1:0]  per_max_o,
  output logic [CNT_W-1:0]  duty_max_o,
  output logic [VAL_W-1:0]  val_min_o,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  logic [2:0]      ctrl_q;
  logic            clr_q;
  logic [ST_W-1:0] status_q, irq_en_q, w1c;

  assign w1c = (wr_en_i && wr_addr_i == A_STATUS) ? wr_data_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      clr_q      <= 1'b0;
      per_min_o  <= '0;
      per_max_o  <= '0;
      duty_max_o <= '0;
      val_min_o  <= '0;
      irq_en_q   <= '0;
    end else begin
      clr_q <= 1'b0;
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CTRL: begin
            ctrl_q <= {wr_data_i[C_VAL], wr_data_i[C_DUTY], wr_data_i[C_PER]};
            clr_q  <= wr_data_i[C_CLR];
          end
          A_PER_MIN: per_min_o  <= wr_data_i;
          A_PER_MAX: per_max_o  <= wr_data_i;
          A_DUTY:    duty_max_o <= wr_data_i;
          A_VALMIN:  val_min_o  <= wr_data_i[VAL_W-1:0];
          A_IRQ_EN:  irq_en_q   <= wr_data_i[ST_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // hardware set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~w1c) | set_i;
  end

  assign per_en_o  = ctrl_q[0];
  assign duty_en_o = ctrl_q[1];
  assign val_en_o  = ctrl_q[2];
  assign clr_o     = clr_q;
  assign status_o  = status_q;
  assign irq_o     = |(status_q & irq_en_q);

  for (genvar b = 0; b < ST_W; b++) begin : g_st_chk
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> status_q[b]);
    p_w1c_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w1c[b] && !set_i[b]) |=> !status_q[b]);
  end

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_q == '0) |-> !irq_o);
endmodule

// File: rtl/clk32_monitor.sv
module clk32_monitor
  import c32m_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int VAL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk32_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  logic             lvl, per_en, duty_en, val_en, clr, mon_en;
  logic             pulse_evt, stall_evt;
  logic [CNT_W-1:0] period, high, per_min, per_max, duty_max;
  logic [VAL_W-1:0] val_min;
  logic [ST_W-1:0]  set;

  assign mon_en = per_en | duty_en | val_en;

  c32m_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(clk32_i), .q_o(lvl)
  );

  c32m_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .mon_en_i(mon_en),
    .clr_i(clr), .per_max_i(per_max), .pulse_evt_o(pulse_evt),
    .period_o(period), .high_o(high), .stall_evt_o(stall_evt)
  );

  c32m_judge #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_evt_i(pulse_evt),
    .period_i(period), .high_i(high), .stall_evt_i(stall_evt),
    .per_min_i(per_min), .per_max_i(per_max), .duty_max_i(duty_max),
    .val_min_i(val_min), .per_en_i(per_en), .duty_en_i(duty_en),
    .val_en_i(val_en), .clr_i(clr), .set_o(set)
  );

  c32m_regs #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .set_i(set),
    .per_en_o(per_en), .duty_en_o(duty_en), .val_en_o(val_en),
    .clr_o(clr), .per_min_o(per_min), .per_max_o(per_max),
    .duty_max_o(duty_max), .val_min_o(val_min),
    .status_o(status_o), .irq_o(irq_o)
  );
endmodule

// File: tb/clk32_monitor_tb.sv
module clk32_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk32 = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [5:0] st;
    logic       irq;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  clk32_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk32_i(clk32), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .status_o(status), .irq_o(irq)
  );

  // monitor: compare one expected item per negative edge
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (status !== it.st || irq !== it.irq) begin
          errors++;
          $display("FAIL %s: status=%h exp=%h irq=%b exp=%b",
                   it.tag, status, it.st, irq, it.irq);
        end
      end
    end
  end

  // all driver tasks start and end on a negative edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_st(input string tag, input logic [5:0] st, input logic ir);
    item_t it;
    it.tag = tag; it.st = st; it.irq = ir;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic pulses(input int n, input int h, input int l);
    for (int i = 0; i < n; i++) begin
      clk32 = 1'b1;
      repeat (h) @(negedge clk);
      clk32 = 1'b0;
      repeat (l) @(negedge clk);
    end
  endtask

  task automatic restart(input logic [2:0] c);
    wr(3'd5, 16'h003F);
    wr(3'd0, {12'd0, 1'b1, c});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_st("R1 reset", 6'h00, 1'b0);

    wr(3'd1, 16'd20);
    wr(3'd2, 16'd30);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd3);

    wr(3'd0, 16'd0);
    pulses(5, 12, 12);
    expect_st("R2 disabled", 6'h00, 1'b0);

    restart(3'b111);
    pulses(3, 12, 12);
    expect_st("R6 two good, not valid", 6'h07, 1'b0);

    restart(3'b111);
    pulses(4, 12, 12);
    expect_st("R6 three good, valid", 6'h0F, 1'b0);

    restart(3'b111);
    pulses(2, 12, 12);
    pulses(1, 20, 20);
    pulses(3, 12, 12);
    expect_st("R6 bad restarts count", 6'h17, 1'b0);

    restart(3'b111);
    pulses(2, 10, 10);
    expect_st("R4 period at min", 6'h07, 1'b0);
    restart(3'b111);
    pulses(2, 15, 15);
    expect_st("R4 period at max", 6'h07, 1'b0);
    restart(3'b111);
    pulses(2, 10, 9);
    expect_st("R4 period below min", 6'h15, 1'b0);
    restart(3'b111);
    pulses(2, 16, 15);
    expect_st("R4 period above max", 6'h15, 1'b0);

    restart(3'b111);
    pulses(2, 14, 10);
    expect_st("R5 duty at limit", 6'h07, 1'b0);
    restart(3'b111);
    pulses(2, 15, 10);
    expect_st("R5 duty over limit", 6'h13, 1'b0);
    restart(3'b101);
    pulses(2, 18, 6);
    expect_st("R5 duty check off", 6'h03, 1'b0);

    restart(3'b100);
    pulses(2, 20, 20);
    expect_st("R3 ready only", 6'h01, 1'b0);

    wr(3'd6, 16'h0020);
    restart(3'b111);
    repeat (50) @(negedge clk);
    expect_st("R7 no stall yet", 6'h00, 1'b0);
    repeat (20) @(negedge clk);
    expect_st("R7 stall and R9 irq", 6'h20, 1'b1);
    wr(3'd6, 16'h0010);
    expect_st("R9 irq masked", 6'h20, 1'b0);
    wr(3'd6, 16'h0000);
    wr(3'd5, 16'h0001);
    expect_st("R8 other bit kept", 6'h20, 1'b0);
    wr(3'd5, 16'h0020);
    expect_st("R8 clear stall", 6'h00, 1'b0);

    // ready is set on the same edge that samples the clear write
    restart(3'b111);
    clk32 = 1'b1;
    repeat (12) @(negedge clk);
    clk32 = 1'b0;
    repeat (12) @(negedge clk);
    clk32 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd5, 16'h0001);
    expect_st("R8 set wins", 6'h07, 1'b0);
    wr(3'd5, 16'h0001);
    expect_st("R8 later clear", 6'h06, 1'b0);
    clk32 = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule